// File: doc/BRIEF.md
# Secondary CPU Bus Ownership and Reset Arbiter

This block decides who owns the bus of a small 8-bit helper processor: the helper itself, or a 16-bit host processor. Two host register writes control it. One raises or drops a bus request, and the other holds the helper in reset or lets it out of reset. Each write carries a single data bit. The arbiter keeps two bits of state: "out of reset" and "bus requested". From those bits it grants the host access to the helper's address space, issues one-cycle reset pulses to the helper and to an attached sound generator, and reports the master-clock count at which the helper resumes. That count is rounded up to the next multiple of the helper's clock divider.

While the host holds no grant, its reads of the helper's area return a fixed open-bus value, and its reads and writes never reach the helper bus. Once granted, host accesses pass straight through. A grant requires both a held request and a released reset. If reset is released while the request is already held, the grant opens and both resets pulse in the same cycle.

Top module: `sub_bus_arbiter`

## Requirements
- R1: After reset the state is zero: grant_o, sub_rst_o, snd_rst_o and restart_vld_o are 0 and restart_cyc_o is 0.
- R2: A request write with data 1 while the helper is out of reset and not requested raises grant_o on the next clock edge. A further request write with data 1 changes nothing.
- R3: A request write with data 1 while the helper is held in reset leaves grant_o at 0. A following reset write with data 1 then raises grant_o and pulses sub_rst_o and snd_rst_o on the same edge, with no restart report.
- R4: A request write with data 0 while granted drops grant_o on the next edge and reports a restart (restart_vld_o for one cycle).
- R5: A reset write with data 1 from the all-zero state pulses sub_rst_o and snd_rst_o for one cycle, leaves grant_o at 0, and reports a restart.
- R6: A reset write with data 1 while the helper is already out of reset produces no pulse and changes neither grant_o nor the state.
- R7: A reset write with data 0 always pulses snd_rst_o, never pulses sub_rst_o, and drops grant_o if it was set.
- R8: On a restart report, restart_cyc_o equals the smallest multiple of 15 that is greater than or equal to mclk_cnt_i sampled with the write. Exact multiples, including 0, come out unchanged. The value holds until the next restart.
- R9: While grant_o is 0, host_rdata_o is 8'hFF and sub_rd_o and sub_wr_o are 0. While grant_o is 1, sub_rd_o and sub_wr_o follow host_rd_i and host_wr_i, and host_rdata_o follows sub_rdata_i.
- R10: When both writes arrive in the same cycle, the request write is applied first and the reset write acts on the result. A restart is reported when the helper goes from stopped to running across the combined update, where running means out of reset and not requested.
- R11: grant_o changes only on the edge after a write. sub_rst_o and snd_rst_o are single-cycle pulses that are 0 in any cycle after a cycle with no reset write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| busreq_we_i | input | 1 | Bus request register write strobe |
| busreq_data_i | input | 1 | 1 = request bus, 0 = release |
| subrst_we_i | input | 1 | Helper reset register write strobe |
| subrst_data_i | input | 1 | 1 = release reset, 0 = hold reset |
| mclk_cnt_i | input | CYC_W | Master-clock count at the write |
| host_rd_i | input | 1 | Host read of helper area |
| host_wr_i | input | 1 | Host write to helper area |
| host_addr_i | input | AW | Host address |
| host_wdata_i | input | DW | Host write data |
| host_rdata_o | output | DW | Read data back to host |
| sub_rd_o | output | 1 | Read strobe on helper bus |
| sub_wr_o | output | 1 | Write strobe on helper bus |
| sub_addr_o | output | AW | Address on helper bus |
| sub_wdata_o | output | DW | Write data on helper bus |
| sub_rdata_i | input | DW | Read data from helper bus |
| grant_o | output | 1 | Host owns helper bus |
| sub_rst_o | output | 1 | Helper reset pulse |
| snd_rst_o | output | 1 | Sound generator reset/stop pulse |
| restart_vld_o | output | 1 | Helper resumed this cycle |
| restart_cyc_o | output | CYC_W+1 | Aligned resume count |

## Verification
The request write and the reset write can land in the same cycle. Their effects then chain: dropping the request can leave the state at zero just before a reset release that restarts the helper, and raising the request just before a reset release opens the grant and fires both resets together. The bench pairs both strobes on purpose in every starting state, and then issues random mixes of paired writes. It checks grant, pulses and restart against a behavioural model that applies the request first and the reset second.

// File: rtl/sub_arb_pkg.sv
package sub_arb_pkg;
  typedef struct packed {
    logic req;   // bus requested
    logic run;   // out of reset
  } arb_state_t;

  localparam arb_state_t ST_ZERO = '{req: 1'b0, run: 1'b0};

  function automatic logic is_running(arb_state_t s);
    return s.run & ~s.req;
  endfunction

  function automatic logic is_granted(arb_state_t s);
    return s.run & s.req;
  endfunction
endpackage

// File: rtl/sub_arb_fsm.sv
module sub_arb_fsm
  import sub_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_we_i,
  input  logic req_data_i,
  input  logic rst_we_i,
  input  logic rst_data_i,
  output logic grant_o,
  output logic sub_rst_o,
  output logic snd_rst_o,
  output logic restart_evt_o
);
  arb_state_t st_q, mid, nxt;
  logic wake, stop;

  always_comb begin
    mid = st_q;
    if (req_we_i) mid.req = req_data_i;
    nxt  = mid;
    wake = 1'b0;
    stop = 1'b0;
    if (rst_we_i) begin
      if (rst_data_i) begin
        wake    = ~mid.run;
        nxt.run = 1'b1;
      end else begin
        stop    = 1'b1;
        nxt.run = 1'b0;
      end
    end
  end

  assign restart_evt_o = is_running(nxt) & ~is_running(st_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_ZERO;
      grant_o   <= 1'b0;
      sub_rst_o <= 1'b0;
      snd_rst_o <= 1'b0;
    end else begin
      st_q      <= nxt;
      grant_o   <= is_granted(nxt);
      sub_rst_o <= wake;
      snd_rst_o <= wake | stop;
    end
  end

  // R11
  grant_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(grant_o) |-> $past(req_we_i | rst_we_i));
  // R3
  sub_rst_pairs_snd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_rst_o |-> snd_rst_o);
  // R7
  hold_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_we_i && !rst_data_i) |=> (snd_rst_o && !sub_rst_o && !grant_o));
  // R11
  pulse_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_we_i |=> (!sub_rst_o && !snd_rst_o));
endmodule

// File: rtl/sub_arb_align.sv
module sub_arb_align #(
  parameter int CYC_W = 20,
  parameter int ALIGN = 15,
  localparam int OUT_W = CYC_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic [CYC_W-1:0] cyc_i,
  output logic             vld_o,
  output logic [OUT_W-1:0] cyc_o
);
  localparam logic [OUT_W-1:0] DIV  = OUT_W'(ALIGN);
  localparam logic [OUT_W-1:0] BIAS = OUT_W'(ALIGN - 1);

  logic [OUT_W-1:0] sum, quo, rnd;

  always_comb begin
    sum = {1'b0, cyc_i} + BIAS;
    quo = sum / DIV;
    rnd = quo * DIV;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      cyc_o <= '0;
    end else begin
      vld_o <= evt_i;
      if (evt_i) cyc_o <= rnd;
    end
  end

  // R8
  aligned_mult_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (cyc_o % DIV) == '0);
  // R8
  aligned_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> (cyc_o >= {1'b0, $past(cyc_i)}) && ((cyc_o - {1'b0, $past(cyc_i)}) < DIV));
endmodule

// File: rtl/sub_arb_gate.sv
module sub_arb_gate #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [DW-1:0] OPEN_BUS = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          grant_i,
  input  logic          host_rd_i,
  input  logic          host_wr_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_rdata_o,
  output logic          sub_rd_o,
  output logic          sub_wr_o,
  output logic [AW-1:0] sub_addr_o,
  output logic [DW-1:0] sub_wdata_o,
  input  logic [DW-1:0] sub_rdata_i
);
  assign sub_rd_o     = host_rd_i & grant_i;
  assign sub_wr_o     = host_wr_i & grant_i;
  assign sub_addr_o   = host_addr_i;
  assign sub_wdata_o  = host_wdata_i;
  assign host_rdata_o = grant_i ? sub_rdata_i : OPEN_BUS;

  // R9
  no_access_ungranted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_i |-> (!sub_rd_o && !sub_wr_o && host_rdata_o == OPEN_BUS));
endmodule

// File: rtl/sub_bus_arbiter.sv
module sub_bus_arbiter #(
  parameter int CYC_W = 20,
  parameter int ALIGN = 15,
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter logic [DW-1:0] OPEN_BUS = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busreq_we_i,
  input  logic             busreq_data_i,
  input  logic             subrst_we_i,
  input  logic             subrst_data_i,
  input  logic [CYC_W-1:0] mclk_cnt_i,
  input  logic             host_rd_i,
  input  logic             host_wr_i,
  input  logic [AW-1:0]    host_addr_i,
  input  logic [DW-1:0]    host_wdata_i,
  output logic [DW-1:0]    host_rdata_o,
  output logic             sub_rd_o,
  output logic             sub_wr_o,
  output logic [AW-1:0]    sub_addr_o,
  output logic [DW-1:0]    sub_wdata_o,
  input  logic [DW-1:0]    sub_rdata_i,
  output logic             grant_o,
  output logic             sub_rst_o,
  output logic             snd_rst_o,
  output logic             restart_vld_o,
  output logic [CYC_W:0]   restart_cyc_o
);
  logic restart_evt;

  sub_arb_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_we_i     (busreq_we_i),
    .req_data_i   (busreq_data_i),
    .rst_we_i     (subrst_we_i),
    .rst_data_i   (subrst_data_i),
    .grant_o      (grant_o),
    .sub_rst_o    (sub_rst_o),
    .snd_rst_o    (snd_rst_o),
    .restart_evt_o(restart_evt)
  );

  sub_arb_align #(.CYC_W(CYC_W), .ALIGN(ALIGN)) u_align (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (restart_evt),
    .cyc_i (mclk_cnt_i),
    .vld_o (restart_vld_o),
    .cyc_o (restart_cyc_o)
  );

  sub_arb_gate #(.AW(AW), .DW(DW), .OPEN_BUS(OPEN_BUS)) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .grant_i     (grant_o),
    .host_rd_i   (host_rd_i),
    .host_wr_i   (host_wr_i),
    .host_addr_i (host_addr_i),
    .host_wdata_i(host_wdata_i),
    .host_rdata_o(host_rdata_o),
    .sub_rd_o    (sub_rd_o),
    .sub_wr_o    (sub_wr_o),
    .sub_addr_o  (sub_addr_o),
    .sub_wdata_o (sub_wdata_o),
    .sub_rdata_i (sub_rdata_i)
  );

  // R4
  restart_not_granted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_vld_o |-> !grant_o);
endmodule

// File: tb/sub_bus_arbiter_tb.sv
module sub_bus_arbiter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_we = 0, req_d = 0, rst_we = 0, rst_d = 0;
  logic [19:0] cyc = '0;
  logic        h_rd = 0, h_wr = 0;
  logic [15:0] h_addr = '0;
  logic [7:0]  h_wdata = '0, s_rdata = '0;
  logic [7:0]  h_rdata, s_wdata;
  logic [15:0] s_addr;
  logic        s_rd, s_wr, grant, sub_rst, snd_rst, rvld;
  logic [20:0] rcyc;

  sub_bus_arbiter dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .busreq_we_i(req_we), .busreq_data_i(req_d),
    .subrst_we_i(rst_we), .subrst_data_i(rst_d),
    .mclk_cnt_i(cyc),
    .host_rd_i(h_rd), .host_wr_i(h_wr), .host_addr_i(h_addr), .host_wdata_i(h_wdata),
    .host_rdata_o(h_rdata), .sub_rd_o(s_rd), .sub_wr_o(s_wr),
    .sub_addr_o(s_addr), .sub_wdata_o(s_wdata), .sub_rdata_i(s_rdata),
    .grant_o(grant), .sub_rst_o(sub_rst), .snd_rst_o(snd_rst),
    .restart_vld_o(rvld), .restart_cyc_o(rcyc)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference: state as an integer, bit0 out of reset, bit1 requested
  int    m_st;
  bit    m_grant, m_sub, m_snd, m_vld;
  int    m_cyc;
  string m_tag;

  always @(posedge clk or negedge rst_n) begin : model
    int s, n;
    bit wake, stop;
    if (!rst_n) begin
      m_st <= 0; m_grant <= 0; m_sub <= 0; m_snd <= 0; m_vld <= 0; m_cyc <= 0;
      m_tag <= "R1";
    end else begin
      s = m_st; n = s; wake = 0; stop = 0;
      if (req_we) n = req_d ? (n | 2) : (n & 1);
      if (rst_we) begin
        if (rst_d) begin wake = (n & 1) == 0; n = n | 1; end
        else begin stop = 1; n = n & 2; end
      end
      m_st    <= n;
      m_grant <= (n == 3);
      m_sub   <= wake;
      m_snd   <= wake | stop;
      m_vld   <= (n == 1) && (s != 1);
      if ((n == 1) && (s != 1)) m_cyc <= ((int'(cyc) + 14) / 15) * 15;
      if (req_we && rst_we)                m_tag <= "R10";
      else if (req_we && req_d)            m_tag <= (s == 0) ? "R3" : "R2";
      else if (req_we)                     m_tag <= "R4";
      else if (rst_we && rst_d)            m_tag <= (s & 1) ? "R6" : ((s == 2) ? "R3" : "R5");
      else if (rst_we)                     m_tag <= "R7";
      else                                 m_tag <= "R11";
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    check(m_tag, "grant_o", int'(grant), int'(m_grant));
    check(m_tag, "sub_rst_o", int'(sub_rst), int'(m_sub));
    check(m_tag, "snd_rst_o", int'(snd_rst), int'(m_snd));
    check(m_tag, "restart_vld_o", int'(rvld), int'(m_vld));
    check("R8", "restart_cyc_o", int'(rcyc), m_cyc);
    check("R9", "host_rdata_o", int'(h_rdata), m_grant ? int'(s_rdata) : 255);
    check("R9", "sub_rd_o", int'(s_rd), int'(h_rd & m_grant));
    check("R9", "sub_wr_o", int'(s_wr), int'(h_wr & m_grant));
    if (m_grant) check("R9", "sub_addr_o", int'(s_addr), int'(h_addr));
  endtask

  task automatic step(bit rqw, bit rqd, bit rsw, bit rsd, int c);
    @(negedge clk);
    compare();
    req_we = rqw; req_d = rqd; rst_we = rsw; rst_d = rsd; cyc = 20'(c);
    h_rd = $urandom_range(0, 1); h_wr = $urandom_range(0, 1);
    h_addr = 16'($urandom); h_wdata = 8'($urandom); s_rdata = 8'($urandom);
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) step(0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare();                                  // R1 reset state
    step(0, 0, 1, 1, 16);   idle(1);            // R5 release from 0: 16 -> 30
    step(1, 1, 0, 0, 0);    idle(2);            // R2 grant
    step(1, 1, 0, 0, 0);    idle(1);            // R2 repeat request
    step(0, 0, 1, 1, 0);    idle(1);            // R6 no effect
    step(1, 0, 0, 0, 30);   idle(1);            // R4 release, exact multiple
    step(0, 0, 1, 0, 0);    idle(1);            // R7 hold reset
    step(1, 1, 0, 0, 0);    idle(1);            // R3 request in reset, no grant
    step(0, 0, 1, 1, 7);    idle(2);            // R3 grant + both pulses
    step(0, 0, 1, 0, 0);    idle(1);            // R7 withdraw grant
    step(1, 0, 1, 1, 0);    idle(1);            // R10 drop req + release -> restart at 0
    step(0, 0, 1, 0, 0);    idle(1);
    step(1, 1, 1, 1, 5);    idle(1);            // R10 request + release -> grant, pulses
    step(1, 0, 1, 0, 1);    idle(1);            // R10 drop + hold
    step(0, 0, 1, 1, 20'hFFFFF); idle(1);       // R8 top of range
    for (int i = 0; i < 600; i++)
      step($urandom_range(0, 3) == 0, $urandom_range(0, 1),
           $urandom_range(0, 3) == 0, $urandom_range(0, 1), int'($urandom_range(0, 20'hFFFFF)));
    idle(2);
    @(negedge clk);
    compare();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule